// File: doc/BRIEF.md
# Key-protected system control register block

This block is a bank of 32-bit control and status words for a system controller. It sits on a simple single-cycle bus: a request is qualified by an enable, writes complete on the clock edge that samples them, and read data appears in a register one cycle later. Software must first unlock the bank by writing a magic value to the key word at offset 0x00. Until it does, every write to a higher offset is refused and flagged.

The bank has several kinds of word:
- Reset-control words, each with a second address that clears bits.
- Two hardware strap words, each with a clear address and a protect word that freezes it.
- PLL extension words that always report lock.
- Read-only revision words.
- A random-number word backed by an LFSR.
- Plain storage words.

Revision, strap and key values come in on input ports and load at reset. A one-cycle error pulse reports the following cases:
- accesses outside the register space or not word-aligned;
- writes to read-only words;
- writes refused by the lock.

A separate lock-violation pulse marks only the refused writes.

Top module: `sysctl_regs`

## Requirements
- R1: A write to offset 0x00 is always accepted. It stores 1 if the data is exactly 0x1688A8A8 and 0 otherwise. A read of 0x00 returns that 0 or 1.
- R2: While the key word holds 0, a write to any in-range aligned offset other than 0x00 changes nothing. It raises both `lock_viol` and `bus_err` for the cycle after the request.
- R3: A write to 0x40 or 0x50 ORs the data into the stored word. A write to 0x44 or 0x54 clears the data's set bits in the word at 0x40 or 0x50 respectively. A read of either address of a pair returns the stored word.
- R4: Strap words at 0x500 and 0x510 take OR writes. Their clear addresses are 0x504 and 0x514. Reads at either address of a pair return the strap word. While the protect word (0x508 for the first strap, 0x518 for the second) is nonzero, set and clear writes to that strap change nothing and raise no error.
- R5: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1.
- R6: Each read of 0x540 returns the current state of a 32-bit LFSR and then advances it, whatever the word at 0x524 holds. The LFSR is seeded with LFSR_SEED (default 0xACE12468) at reset. Its next state is {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R7: Writes to 0x04, 0x14 and 0x540 made while unlocked change nothing. They raise `bus_err` but not `lock_viol`.
- R8: After reset, the words hold the following values:

  | Offset | Value |
  |---|---|
  | 0x40 | 0xF7CFFFDC |
  | 0x50 | 0xFFFFFFFC |
  | 0x80 | 0xEFF43E8B |
  | 0x90 | 0xFFF0FFF0 |
  | 0x200 | 0x1000405F |
  | 0x04 and 0x14 | `rev_in` |
  | 0x500 | `strap1_in` |
  | 0x510 | `strap2_in` |
  | 0x00 | `key_init` |
  | all other words | 0 |

- R9: An access at or beyond 0xE20, or with bus_addr[1:0] nonzero, has the following effects: it returns 0 on a read, discards a write, raises `bus_err` and does not raise `lock_viol`.
- R10: Offsets 0x80, 0x90, 0x200, 0x204, 0x224, 0x244, 0x300, 0x304, 0x310, 0x508, 0x518 and 0x524 are plain read/write storage.
- R11: The following timing and idle rules apply:
  - `bus_rdata` is loaded one cycle after a read request and holds its value otherwise.
  - `bus_err` and `lock_viol` are low in any cycle not following a request.
  - In-range aligned unnamed offsets read 0, ignore writes and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse |
| lock_viol | output | 1 | One-cycle pulse on a write refused by the lock |
| rev_in | input | 32 | Revision value loaded into both revision words at reset |
| strap1_in | input | 32 | First strap value loaded at reset |
| strap2_in | input | 32 | Second strap value loaded at reset |
| key_init | input | 1 | Key word value loaded at reset |

## Verification
The assertions assume the following about the inputs:
- `bus_we`, `bus_addr` and `bus_wdata` are known whenever `bus_en` is high.
- Only one request is presented per cycle.
- The reset-time inputs are steady while `rst` is high.

The bench keeps to these assumptions in three ways. It drives every request field at the falling edge, holds one request for exactly one cycle, and returns `bus_en` to 0 between requests. It also changes the strap, revision and key inputs only before asserting reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [31:0] UNLOCK_MAGIC = 32'h1688_A8A8;

  typedef enum logic [4:0] {
    S_KEY, S_REV1, S_REV2, S_RST1, S_RST2, S_CLK1, S_CLK2, S_PLLP,
    S_HPLLX, S_MPLLX, S_EPLLX, S_SEL1, S_SEL2, S_SEL3,
    S_STRAP1, S_STRAP2, S_SPROT1, S_SPROT2, S_RNGC
  } slot_e;

  localparam int NSLOT = 19;

  typedef enum logic [2:0] {
    OP_NONE, OP_PLAIN, OP_SET, OP_CLR, OP_KEY, OP_RO, OP_RNG
  } op_e;

  typedef struct packed {
    op_e   op;
    slot_e slot;
    logic  pll;
    logic  strap;
    slot_e guard;
  } dec_t;

  function automatic logic [31:0] const_reset(slot_e s);
    case (s)
      S_RST1:  return 32'hF7CF_FFDC;
      S_RST2:  return 32'hFFFF_FFFC;
      S_CLK1:  return 32'hEFF4_3E8B;
      S_CLK2:  return 32'hFFF0_FFF0;
      S_PLLP:  return 32'h1000_405F;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned SPACE_END = 32'hE20
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic              ok
);
  logic [31:0] a;
  assign a  = 32'(addr);
  assign ok = (addr[1:0] == 2'b00) && (a < SPACE_END);

  always_comb begin
    dec = '{op: OP_NONE, slot: S_KEY, pll: 1'b0, strap: 1'b0, guard: S_KEY};
    case (a)
      32'h000: begin dec.op = OP_KEY;   dec.slot = S_KEY;    end
      32'h004: begin dec.op = OP_RO;    dec.slot = S_REV1;   end
      32'h014: begin dec.op = OP_RO;    dec.slot = S_REV2;   end
      32'h040: begin dec.op = OP_SET;   dec.slot = S_RST1;   end
      32'h044: begin dec.op = OP_CLR;   dec.slot = S_RST1;   end
      32'h050: begin dec.op = OP_SET;   dec.slot = S_RST2;   end
      32'h054: begin dec.op = OP_CLR;   dec.slot = S_RST2;   end
      32'h080: begin dec.op = OP_PLAIN; dec.slot = S_CLK1;   end
      32'h090: begin dec.op = OP_PLAIN; dec.slot = S_CLK2;   end
      32'h200: begin dec.op = OP_PLAIN; dec.slot = S_PLLP;   end
      32'h204: begin dec.op = OP_PLAIN; dec.slot = S_HPLLX; dec.pll = 1'b1; end
      32'h224: begin dec.op = OP_PLAIN; dec.slot = S_MPLLX; dec.pll = 1'b1; end
      32'h244: begin dec.op = OP_PLAIN; dec.slot = S_EPLLX; dec.pll = 1'b1; end
      32'h300: begin dec.op = OP_PLAIN; dec.slot = S_SEL1;   end
      32'h304: begin dec.op = OP_PLAIN; dec.slot = S_SEL2;   end
      32'h310: begin dec.op = OP_PLAIN; dec.slot = S_SEL3;   end
      32'h500: begin dec.op = OP_SET; dec.slot = S_STRAP1; dec.strap = 1'b1; dec.guard = S_SPROT1; end
      32'h504: begin dec.op = OP_CLR; dec.slot = S_STRAP1; dec.strap = 1'b1; dec.guard = S_SPROT1; end
      32'h508: begin dec.op = OP_PLAIN; dec.slot = S_SPROT1; end
      32'h510: begin dec.op = OP_SET; dec.slot = S_STRAP2; dec.strap = 1'b1; dec.guard = S_SPROT2; end
      32'h514: begin dec.op = OP_CLR; dec.slot = S_STRAP2; dec.strap = 1'b1; dec.guard = S_SPROT2; end
      32'h518: begin dec.op = OP_PLAIN; dec.slot = S_SPROT2; end
      32'h524: begin dec.op = OP_PLAIN; dec.slot = S_RNGC;   end
      32'h540: begin dec.op = OP_RNG;   dec.slot = S_RNGC;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [31:0] value
);
  logic [31:0] st_q;
  assign value = st_q;

  always_ff @(posedge clk) begin
    if (rst)       st_q <= SEED;
    else if (step) st_q <= {st_q[30:0], st_q[31] ^ st_q[21] ^ st_q[1] ^ st_q[0]};
  end

  // R6: a step from a nonzero state never produces the all-zero lock-up state
  a_r6_no_lockup: assert property (@(posedge clk) disable iff (rst)
    step |=> (st_q != 32'h0));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned SPACE_END = 32'hE20,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              lock_viol,
  input  logic [31:0]       rev_in,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       strap2_in,
  input  logic              key_init
);
  localparam int SLOTS = NSLOT;

  logic [31:0] regs_q [SLOTS];
  dec_t        dec;
  logic        ok;
  logic [31:0] rnd;
  logic        wr, rd, unlocked, blocked, ro_hit, frozen, wr_go, rng_step;
  logic [31:0] rd_val;
  logic [31:0] rdata_q;
  logic        err_q, lock_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .SPACE_END(SPACE_END)) u_dec (
    .addr(bus_addr), .dec(dec), .ok(ok)
  );

  sysctl_lfsr #(.SEED(LFSR_SEED)) u_rng (
    .clk(clk), .rst(rst), .step(rng_step), .value(rnd)
  );

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign unlocked = regs_q[S_KEY][0];
  assign blocked  = wr && ok && (bus_addr != '0) && !unlocked;
  assign ro_hit   = wr && ok && !blocked && (dec.op == OP_RO || dec.op == OP_RNG);
  assign wr_go    = wr && ok && !blocked;
  assign frozen   = dec.strap && (regs_q[dec.guard] != 32'h0);
  assign rng_step = rd && ok && (dec.op == OP_RNG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) regs_q[i] <= const_reset(slot_e'(i));
      regs_q[S_REV1]   <= rev_in;
      regs_q[S_REV2]   <= rev_in;
      regs_q[S_STRAP1] <= strap1_in;
      regs_q[S_STRAP2] <= strap2_in;
      regs_q[S_KEY]    <= {31'b0, key_init};
    end else if (wr_go) begin
      case (dec.op)
        OP_KEY:   regs_q[S_KEY] <= {31'b0, bus_wdata == UNLOCK_MAGIC};
        OP_PLAIN: regs_q[dec.slot] <= bus_wdata;
        OP_SET:   if (!frozen) regs_q[dec.slot] <= regs_q[dec.slot] | bus_wdata;
        OP_CLR:   if (!frozen) regs_q[dec.slot] <= regs_q[dec.slot] & ~bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_val = 32'h0;
    if (ok) begin
      case (dec.op)
        OP_NONE: rd_val = 32'h0;
        OP_RNG:  rd_val = rnd;
        default: rd_val = regs_q[dec.slot] | {dec.pll, 31'b0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 32'h0;
      err_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_val;
      err_q  <= (bus_en && !ok) || blocked || ro_hit;
      lock_q <= blocked;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign lock_viol = lock_q;

  // R1: key word stores 1 only for the magic value
  a_r1_key_store: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == '0) |=>
      (regs_q[S_KEY] == {31'b0, $past(bus_wdata) == UNLOCK_MAGIC}));
  // R2: refused writes pulse both flags and leave a control word untouched
  a_r2_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && ok && bus_addr != '0 && !unlocked) |=>
      (lock_viol && bus_err && $stable(regs_q[S_RST1])));
  // R4: a protected strap keeps its value
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && ok && dec.strap && regs_q[dec.guard] != 32'h0) |=>
      ($stable(regs_q[S_STRAP1]) && $stable(regs_q[S_STRAP2])));
  // R5: PLL words always read as locked
  a_r5_pll_lock: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && ok && dec.pll) |=> bus_rdata[31]);
  // R7: read-only words reject writes with an error only
  a_r7_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && ok && unlocked && (dec.op == OP_RO || dec.op == OP_RNG)) |=>
      (bus_err && !lock_viol && $stable(regs_q[S_REV1]) && $stable(regs_q[S_REV2])));
  // R9: out-of-range or misaligned reads give zero and an error
  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !ok) |=> (bus_err && !lock_viol && ($past(bus_we) || bus_rdata == 32'h0)));
  // R11: read data holds without a read; flags stay low when idle
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> (!bus_err && !lock_viol));
endmodule

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;
  localparam logic [31:0] MAGIC = 32'h1688_A8A8;
  localparam logic [31:0] SEED  = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, lock_viol;
  logic [31:0] rev_in = 32'h0500_0303, strap1_in = 32'h00A5_5A0F, strap2_in = 32'h1234_0000;
  logic        key_init = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_regs dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .lock_viol(lock_viol),
    .rev_in(rev_in), .strap1_in(strap1_in), .strap2_in(strap2_in), .key_init(key_init)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mdl [1024];
  logic [31:0] lf;
  logic [31:0] got_rd;
  logic        got_err, got_lock;

  function automatic logic [31:0] lf_next(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 1024; i++) mdl[i] = 32'h0;
    mdl['h040 >> 2] = 32'hF7CF_FFDC; mdl['h050 >> 2] = 32'hFFFF_FFFC;
    mdl['h080 >> 2] = 32'hEFF4_3E8B; mdl['h090 >> 2] = 32'hFFF0_FFF0;
    mdl['h200 >> 2] = 32'h1000_405F;
    mdl['h004 >> 2] = rev_in; mdl['h014 >> 2] = rev_in;
    mdl['h500 >> 2] = strap1_in; mdl['h510 >> 2] = strap2_in;
    mdl[0] = {31'b0, key_init};
    lf = SEED;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_op(logic we, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    got_rd = bus_rdata; got_err = bus_err; got_lock = lock_viol;
    bus_en = 1'b0;
  endtask

  function automatic bit bad(logic [11:0] a);
    return (a[1:0] != 2'b00) || (a >= 12'hE20);
  endfunction

  task automatic wr_check(string req, logic [11:0] a, logic [31:0] d);
    logic e, l;
    int w;
    w = int'(a >> 2);
    e = 1'b0; l = 1'b0;
    if (bad(a)) e = 1'b1;
    else if (a != 12'h0 && mdl[0] == 32'h0) begin e = 1'b1; l = 1'b1; end
    else case (a)
      12'h000: mdl[0] = {31'b0, d == MAGIC};
      12'h004, 12'h014, 12'h540: e = 1'b1;
      12'h040, 12'h050: mdl[w] = mdl[w] | d;
      12'h044, 12'h054: mdl[w-1] = mdl[w-1] & ~d;
      12'h500, 12'h510: if (mdl[w+2] == 32'h0) mdl[w] = mdl[w] | d;
      12'h504, 12'h514: if (mdl[w+1] == 32'h0) mdl[w-1] = mdl[w-1] & ~d;
      12'h080, 12'h090, 12'h200, 12'h204, 12'h224, 12'h244, 12'h300, 12'h304,
      12'h310, 12'h508, 12'h518, 12'h524: mdl[w] = d;
      default: ;
    endcase
    bus_op(1'b1, a, d);
    chk(req, $sformatf("write err @%h", a), {31'b0, got_err}, {31'b0, e});
    chk(req, $sformatf("write lock @%h", a), {31'b0, got_lock}, {31'b0, l});
  endtask

  task automatic rd_check(string req, logic [11:0] a);
    logic [31:0] x;
    int w;
    w = int'(a >> 2);
    if (bad(a)) x = 32'h0;
    else case (a)
      12'h044, 12'h054, 12'h504, 12'h514: x = mdl[w-1];
      12'h204, 12'h224, 12'h244: x = mdl[w] | 32'h8000_0000;
      12'h540: begin x = lf; lf = lf_next(lf); end
      default: x = mdl[w];
    endcase
    bus_op(1'b0, a, 32'h0);
    chk(req, $sformatf("read data @%h", a), got_rd, x);
    chk(req, $sformatf("read err @%h", a), {31'b0, got_err}, {31'b0, bad(a)});
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R8 (and R9/R6 for the tail and RNG word): full sweep of reset contents
    for (int i = 0; i < 1024; i++) rd_check("R8", 12'(i * 4));
    // R2: writes refused while locked
    wr_check("R2", 12'h080, 32'h0);
    wr_check("R2", 12'h500, 32'hFFFF_FFFF);
    rd_check("R2", 12'h080);
    rd_check("R2", 12'h500);
    // R1: key behaviour
    wr_check("R1", 12'h000, MAGIC + 1);
    rd_check("R1", 12'h000);
    wr_check("R1", 12'h000, MAGIC);
    rd_check("R1", 12'h000);
    // R3: set/clear pairs
    wr_check("R3", 12'h040, 32'h0000_0023);
    rd_check("R3", 12'h040);
    wr_check("R3", 12'h044, 32'hF000_0001);
    rd_check("R3", 12'h040);
    rd_check("R3", 12'h044);
    wr_check("R3", 12'h054, 32'hFFFF_0000);
    wr_check("R3", 12'h050, 32'h0001_0003);
    rd_check("R3", 12'h054);
    // R4: straps and protect words
    wr_check("R4", 12'h504, 32'h0000_000F);
    wr_check("R4", 12'h500, 32'hC000_0000);
    rd_check("R4", 12'h500);
    wr_check("R4", 12'h508, 32'h0000_0001);
    wr_check("R4", 12'h500, 32'h0000_FFFF);
    wr_check("R4", 12'h504, 32'hFFFF_FFFF);
    rd_check("R4", 12'h504);
    wr_check("R4", 12'h510, 32'h0000_00AA);
    wr_check("R4", 12'h514, 32'h1000_0000);
    rd_check("R4", 12'h510);
    wr_check("R4", 12'h518, 32'h8000_0000);
    wr_check("R4", 12'h514, 32'hFFFF_FFFF);
    rd_check("R4", 12'h514);
    wr_check("R4", 12'h508, 32'h0);
    wr_check("R4", 12'h504, 32'hFFFF_FFFF);
    rd_check("R4", 12'h500);
    // R5: PLL lock bit
    wr_check("R5", 12'h204, 32'h1234_5678);
    rd_check("R5", 12'h204);
    wr_check("R5", 12'h224, 32'h0);
    rd_check("R5", 12'h224);
    wr_check("R5", 12'h244, 32'h7FFF_FFFF);
    rd_check("R5", 12'h244);
    // R6: random word advances per read regardless of the control word
    wr_check("R6", 12'h524, 32'h0);
    for (int i = 0; i < 4; i++) rd_check("R6", 12'h540);
    wr_check("R6", 12'h524, 32'h0000_0004);
    for (int i = 0; i < 4; i++) rd_check("R6", 12'h540);
    rd_check("R6", 12'h524);
    // R7: read-only words
    wr_check("R7", 12'h004, 32'hDEAD_BEEF);
    wr_check("R7", 12'h014, 32'hDEAD_BEEF);
    wr_check("R7", 12'h540, 32'hDEAD_BEEF);
    rd_check("R7", 12'h004);
    rd_check("R7", 12'h014);
    rd_check("R7", 12'h540);
    // R9: out of range and misaligned
    wr_check("R9", 12'h042, 32'hFFFF_FFFF);
    rd_check("R9", 12'h040);
    rd_check("R9", 12'h082);
    wr_check("R9", 12'hE20, 32'h1);
    rd_check("R9", 12'hE20);
    wr_check("R9", 12'hFFC, 32'h1);
    rd_check("R9", 12'hFFC);
    // R10: plain storage with two patterns each
    for (int p = 0; p < 2; p++) begin
      logic [11:0] plain [12] = '{12'h080, 12'h090, 12'h200, 12'h204, 12'h224, 12'h244,
                                  12'h300, 12'h304, 12'h310, 12'h508, 12'h518, 12'h524};
      for (int i = 0; i < 12; i++) begin
        wr_check("R10", plain[i], (p == 0) ? (32'h0101_0101 * 32'(i + 1)) : ~(32'h0101_0101 * 32'(i + 1)));
        rd_check("R10", plain[i]);
      end
    end
    // R11: hold and idle behaviour, unnamed offsets
    rd_check("R11", 12'h300);
    @(negedge clk);
    chk("R11", "rdata hold", bus_rdata, got_rd);
    chk("R11", "idle err", {31'b0, bus_err}, 32'h0);
    chk("R11", "idle lock", {31'b0, lock_viol}, 32'h0);
    wr_check("R11", 12'h084, 32'hFFFF_FFFF);
    rd_check("R11", 12'h084);
    wr_check("R11", 12'hE1C, 32'h5555_5555);
    rd_check("R11", 12'hE1C);
    // R2 again after relocking
    wr_check("R2", 12'h000, 32'h0);
    wr_check("R2", 12'h300, 32'h0);
    rd_check("R2", 12'h300);
    // R8: second reset with new inputs and key preset
    rev_in = 32'h0501_0303; strap1_in = 32'hFFFF_0000; strap2_in = 32'h0000_FFFF; key_init = 1'b1;
    do_reset();
    for (int i = 0; i < 1024; i++) rd_check("R8", 12'(i * 4));
    wr_check("R1", 12'h300, 32'hABCD_0123);
    rd_check("R1", 12'h300);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule